// File: doc/BRIEF.md
# Byte-Writable Synchronous SRAM Array

This block is a single-clock synchronous static RAM. On every rising edge it captures the address, the write data and the write controls into an input register stage. A write then completes on the following edge with no further strobe. It updates either the whole word or only the byte lanes that are enabled. A read returns the stored word at the registered address one clock after capture.

The word is made of `LANES` byte lanes of `LANE_W` bits each. The defaults are four 9-bit lanes, giving a 36-bit word in which each lane holds 8 data bits and one parity bit. The depth is `2**ADDR_W` words and is kept small by default.

All write controls are active low:
- The whole-word write control writes every lane, whatever the other controls say.
- Lane selects take effect only when the lane-write qualifier is also low.
- A cycle with both the whole-word write and the qualifier high is a read.

Top module: `bwsram`

## Requirements
- R1: While `rst_n` is low, and after its release until the first read result is produced, `rdata_o` is all zeros.
- R2: A read presented before rising edge k (`wr_all_n`=1 and `lane_qual_n`=1) drives the word stored at `addr_i` onto `rdata_o` after edge k+1.
- R3: With `wr_all_n`=0, all lanes of the addressed word take `wdata_i`, whatever the values of `lane_qual_n` and `lane_sel_n`.
- R4: With `wr_all_n`=1 and `lane_qual_n`=0, exactly the lanes i with `lane_sel_n[i]`=0 take lane i of `wdata_i`. All other lanes keep their previous contents.
- R5: With `lane_qual_n`=1 and `wr_all_n`=1, the cycle is a read whatever `lane_sel_n` holds, and no stored lane changes.
- R6: A lane write may update any number of lanes, from zero to all four. `lane_qual_n`=0 with every `lane_sel_n` bit high is a write cycle that changes nothing.
- R7: `rdata_o` keeps its value through the output update that belongs to a write cycle.
- R8: A read of an address issued in the cycle right after a write to that address returns the newly written data.
- R9: Lane i occupies bits [LANE_W*i+LANE_W-1 : LANE_W*i] of `wdata_i` and `rdata_o`, and is controlled by `lane_sel_n[i]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset of the register stages |
| addr_i | input | ADDR_W | Word address |
| wdata_i | input | LANES*LANE_W | Write data, lane 0 in the low bits |
| wr_all_n | input | 1 | Whole-word write, active low |
| lane_qual_n | input | 1 | Qualifier for the lane selects, active low |
| lane_sel_n | input | LANES | Per-lane write selects, active low |
| rdata_o | output | LANES*LANE_W | Registered read data |

## Verification
The hardest case to reach is a mixed lane write in which some lanes change and the neighbouring lanes must keep older data. The neighbouring lanes must also hold values that differ from the new data, so that a wrong merge can be seen. The stimulus first fills every word with the whole-word write, using random data. It then issues single-lane writes, empty lane writes and writes with the qualifier disabled. Each of these is followed by a read of the same address. Long random runs then mix the three control inputs over the full address space.

// File: rtl/bwsram_pkg.sv
package bwsram_pkg;

  typedef enum logic {
    CYC_READ  = 1'b0,
    CYC_WRITE = 1'b1
  } cyc_kind_e;

  // A cycle reads only when neither write control is active.
  function automatic cyc_kind_e classify_cycle(input logic wr_all_n, input logic lane_qual_n);
    return (wr_all_n && lane_qual_n) ? CYC_READ : CYC_WRITE;
  endfunction

  // Write strobe of one lane from the active-low controls.
  function automatic logic lane_strobe(input logic wr_all_n, input logic lane_qual_n,
                                       input logic sel_n);
    return (!wr_all_n) || (!lane_qual_n && !sel_n);
  endfunction

endpackage

// File: rtl/bwsram_inreg.sv
module bwsram_inreg #(
  parameter int ADDR_W = 4,
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  localparam int DATA_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              wr_all_n,
  input  logic              lane_qual_n,
  input  logic [LANES-1:0]  lane_sel_n,
  output logic              cap_vld,
  output logic [ADDR_W-1:0] cap_addr,
  output logic [DATA_W-1:0] cap_wdata,
  output logic              cap_all_n,
  output logic              cap_qual_n,
  output logic [LANES-1:0]  cap_sel_n
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_vld    <= 1'b0;
      cap_addr   <= '0;
      cap_wdata  <= '0;
      cap_all_n  <= 1'b1;
      cap_qual_n <= 1'b1;
      cap_sel_n  <= '1;
    end else begin
      cap_vld    <= 1'b1;
      cap_addr   <= addr_i;
      cap_wdata  <= wdata_i;
      cap_all_n  <= wr_all_n;
      cap_qual_n <= lane_qual_n;
      cap_sel_n  <= lane_sel_n;
    end
  end

endmodule

// File: rtl/bwsram_lane_dec.sv
module bwsram_lane_dec
  import bwsram_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic             cap_vld,
  input  logic             cap_all_n,
  input  logic             cap_qual_n,
  input  logic [LANES-1:0] cap_sel_n,
  output logic [LANES-1:0] lane_we,
  output logic             rd_en
);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_we[g] = cap_vld && lane_strobe(cap_all_n, cap_qual_n, cap_sel_n[g]);
  end

  assign rd_en = cap_vld && (classify_cycle(cap_all_n, cap_qual_n) == CYC_READ);

endmodule

// File: rtl/bwsram_store.sv
module bwsram_store #(
  parameter int ADDR_W = 4,
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  localparam int DATA_W = LANES * LANE_W,
  localparam int DEPTH  = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [LANES-1:0]  lane_we,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rdata
);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
      if (lane_we[g]) cells[addr] <= wdata[g*LANE_W +: LANE_W];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     rdata[g*LANE_W +: LANE_W] <= '0;
      else if (rd_en) rdata[g*LANE_W +: LANE_W] <= cells[addr];
    end
  end

endmodule

// File: rtl/bwsram.sv
module bwsram #(
  parameter int ADDR_W = 4,
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  localparam int DATA_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              wr_all_n,
  input  logic              lane_qual_n,
  input  logic [LANES-1:0]  lane_sel_n,
  output logic [DATA_W-1:0] rdata_o
);

  // Named internal events, exposed for the checker.
  logic              cap_vld;
  logic [ADDR_W-1:0] cap_addr;
  logic [DATA_W-1:0] cap_wdata;
  logic              cap_all_n;
  logic              cap_qual_n;
  logic [LANES-1:0]  cap_sel_n;
  logic [LANES-1:0]  lane_we;
  logic              rd_en;

  bwsram_inreg #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_inreg (
    .clk        (clk),
    .rst_n      (rst_n),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .wr_all_n   (wr_all_n),
    .lane_qual_n(lane_qual_n),
    .lane_sel_n (lane_sel_n),
    .cap_vld    (cap_vld),
    .cap_addr   (cap_addr),
    .cap_wdata  (cap_wdata),
    .cap_all_n  (cap_all_n),
    .cap_qual_n (cap_qual_n),
    .cap_sel_n  (cap_sel_n)
  );

  bwsram_lane_dec #(.LANES(LANES)) u_dec (
    .cap_vld   (cap_vld),
    .cap_all_n (cap_all_n),
    .cap_qual_n(cap_qual_n),
    .cap_sel_n (cap_sel_n),
    .lane_we   (lane_we),
    .rd_en     (rd_en)
  );

  bwsram_store #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_store (
    .clk    (clk),
    .rst_n  (rst_n),
    .addr   (cap_addr),
    .wdata  (cap_wdata),
    .lane_we(lane_we),
    .rd_en  (rd_en),
    .rdata  (rdata_o)
  );

endmodule

// File: rtl/bwsram_chk.sv
module bwsram_chk #(
  parameter int LANES  = 4,
  parameter int DATA_W = 36
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_all_n,
  input logic              lane_qual_n,
  input logic [LANES-1:0]  lane_sel_n,
  input logic [LANES-1:0]  lane_we,
  input logic              rd_en,
  input logic [DATA_W-1:0] rdata_o
);

  // R1
  reset_clear_chk: assert property (@(posedge clk) !rst_n |=> rdata_o == '0);

  // R3
  global_all_lanes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(wr_all_n)) |-> (lane_we == {LANES{1'b1}}));

  // R4
  lane_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(wr_all_n) && !$past(lane_qual_n)) |-> (lane_we == ~$past(lane_sel_n)));

  // R5
  qual_off_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(wr_all_n) && $past(lane_qual_n)) |-> (lane_we == '0 && rd_en));

  // R7
  write_holds_rdata_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_all_n && lane_qual_n) |-> ##2 $stable(rdata_o));

  // R6
  strobe_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> ($countones(lane_we) == 0));

endmodule

bind bwsram bwsram_chk #(.LANES(LANES), .DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .wr_all_n   (wr_all_n),
  .lane_qual_n(lane_qual_n),
  .lane_sel_n (lane_sel_n),
  .lane_we    (lane_we),
  .rd_en      (rd_en),
  .rdata_o    (rdata_o)
);

// File: tb/bwsram_test.sv
module bwsram_test;
  localparam int ADDR_W = 4;
  localparam int LANES  = 4;
  localparam int LANE_W = 9;
  localparam int DATA_W = LANES * LANE_W;
  localparam int DEPTH  = 1 << ADDR_W;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [ADDR_W-1:0] addr_i = '0;
  logic [DATA_W-1:0] wdata_i = '0;
  logic              wr_all_n = 1'b1;
  logic              lane_qual_n = 1'b1;
  logic [LANES-1:0]  lane_sel_n = '1;
  logic [DATA_W-1:0] rdata_o;

  int checks = 0;
  int fails = 0;
  logic [DATA_W-1:0] model [DEPTH];
  logic [DATA_W-1:0] pend_exp = '0;
  string             pend_tag = "R1";
  logic [DATA_W-1:0] last_rd = '0;

  always #2ns clk = ~clk;

  bwsram #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) uut (
    .clk(clk), .rst_n(rst_n), .addr_i(addr_i), .wdata_i(wdata_i),
    .wr_all_n(wr_all_n), .lane_qual_n(lane_qual_n), .lane_sel_n(lane_sel_n),
    .rdata_o(rdata_o)
  );

  // Reference merge: build a bit mask of the lanes that are written.
  function automatic logic [DATA_W-1:0] merge(input logic [DATA_W-1:0] old_w,
      input logic [DATA_W-1:0] new_w, input logic all_n, input logic qual_n,
      input logic [LANES-1:0] sel_n);
    logic [DATA_W-1:0] m;
    m = '0;
    for (int i = 0; i < LANES; i++)
      if (all_n == 1'b0 || (qual_n == 1'b0 && sel_n[i] == 1'b0))
        m[i*LANE_W +: LANE_W] = {LANE_W{1'b1}};
    return (new_w & m) | (old_w & ~m);
  endfunction

  task automatic check(input string tag, input logic [DATA_W-1:0] act,
                       input logic [DATA_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: rdata_o=%h expected %h", tag, act, exp);
    end
  endtask

  // One cycle: drive, pass an edge, then check the previous operation's result.
  task automatic op(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d,
                    input logic all_n, input logic qual_n, input logic [LANES-1:0] sel_n,
                    input string tag);
    logic [DATA_W-1:0] e;
    addr_i = a; wdata_i = d; wr_all_n = all_n; lane_qual_n = qual_n; lane_sel_n = sel_n;
    if (all_n && qual_n) begin
      e = model[a];
      last_rd = e;
    end else begin
      model[a] = merge(model[a], d, all_n, qual_n, sel_n);
      e = last_rd;
    end
    @(posedge clk);
    @(negedge clk);
    check(pend_tag, rdata_o, pend_exp);
    pend_exp = e;
    pend_tag = tag;
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, input string tag);
    op(a, '0, 1'b1, 1'b1, '1, tag);
  endtask

  function automatic logic [DATA_W-1:0] rnd_word();
    return {$urandom, $urandom};
  endfunction

  initial begin
    #400000ns;
    fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks + 1);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check("R1", rdata_o, '0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", rdata_o, '0);

    // R3: fill every word with a whole-word write; lane controls are random noise.
    for (int a = 0; a < DEPTH; a++)
      op(a[ADDR_W-1:0], rnd_word(), 1'b0, 1'(($urandom)), 4'($urandom), "R7");
    for (int a = 0; a < DEPTH; a++) rd(a[ADDR_W-1:0], "R3");

    // R4 / R9: one lane at a time, then a read of the same word (R8 back to back).
    for (int i = 0; i < LANES; i++) begin
      op(4'd5, rnd_word(), 1'b1, 1'b0, ~(4'b1 << i), "R7");
      rd(4'd5, "R9");
    end
    op(4'd6, rnd_word(), 1'b1, 1'b0, 4'b0101, "R7");
    rd(4'd6, "R4");
    op(4'd7, rnd_word(), 1'b1, 1'b0, 4'b0000, "R7");
    rd(4'd7, "R8");

    // R6: qualifier low but no lane selected changes nothing.
    op(4'd3, rnd_word(), 1'b1, 1'b0, 4'b1111, "R7");
    rd(4'd3, "R6");

    // R5: lane selects without the qualifier act as a read.
    rd(4'd9, "R2");
    op(4'd9, rnd_word(), 1'b1, 1'b1, 4'b0000, "R5");
    rd(4'd9, "R5");

    // Random mix.
    for (int n = 0; n < 3000; n++) begin
      int k;
      k = $urandom_range(0, 3);
      if (k == 0) rd(4'($urandom), "R2");
      else op(4'($urandom), rnd_word(), (k != 1), 1'($urandom), 4'($urandom),
              (k == 3) ? "R5" : "R4");
    end
    rd(4'd0, "R2");
    rd(4'd1, "R2");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule